// File: doc/BRIEF.md
# Serial-In Latched Parallel-Out Register

This block turns a serial bit stream into a parallel output word. It has two register stages. A shift stage takes one bit per rising edge of a shift strobe. An output stage takes a copy of the whole shift stage in a single step on a rising edge of a latch strobe. The parallel outputs are driven only from the output stage. They therefore stay steady while a new word is shifted in, and they change all at once when the word is latched.

Both strobes are ordinary synchronous inputs. They are sampled on the system clock, and each rising edge is detected once, no matter how long the strobe stays high. An active-low clear empties only the shift stage. An active-low output enable stands in for a high-impedance output: an explicit enable flag shows whether the outputs are driven, and the data lines read zero while they are off. The top bit of the shift stage comes out as a cascade output. Wiring it to the serial input of a second instance, with both instances sharing the strobes, builds one longer register.

Top module: `sipo_latch_reg`

## Requirements
- R1: A detected rising edge of `shift_stb` loads `ser_in` into shift-stage bit 0 and moves every other shift-stage bit up one position. The stage is updated on the same system clock edge on which the strobe is first sampled high.
- R2: While no rising edge of `latch_stb` is detected, `par_q` holds its value, even while shifting or clearing goes on.
- R3: A detected rising edge of `latch_stb` copies all WIDTH shift-stage bits into the output stage on that clock edge.
- R4: While `clr_n` is low, the shift stage becomes zero, and the clear wins over a shift edge in the same cycle. The output stage is left unchanged.
- R5: While `oe_n` is high, `par_en` is 0 and `par_q` reads all zeros. While `oe_n` is low, `par_en` is 1 and `par_q` shows the output stage.
- R6: `cas_out` always equals shift-stage bit WIDTH-1 and does not depend on `oe_n`.
- R7: When a word is shifted most-significant bit first with WIDTH shift edges and then latched, `par_q` equals that word, so the first bit sent appears on `par_q[7]`.
- R8: In two instances chained through `cas_out`, 16 bits sent MSB first leave the first 8 bits sent in the far instance and the last 8 in the near one.
- R9: When both strobes rise in the same cycle, the output stage takes the shift-stage value from before that shift.
- R10: During reset, both stages and both edge detectors are zero.
- R11: A strobe held high for several clock cycles counts as one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial data input |
| shift_stb | input | 1 | Shift strobe; a rising edge shifts once |
| latch_stb | input | 1 | Latch strobe; a rising edge copies the shift stage |
| clr_n | input | 1 | Active-low clear of the shift stage only |
| oe_n | input | 1 | Active-low output enable |
| par_q | output | WIDTH | Parallel output word, zero while disabled |
| par_en | output | 1 | High when the parallel outputs are driven |
| cas_out | output | 1 | Top shift-stage bit, for chaining |

## Verification
The shift stage has no port of its own. A wrong shift-stage bit shows up on `cas_out` only once it reaches the top position, which can take up to WIDTH shift edges. It shows up on `par_q` only after the next latch edge. The bench therefore latches right after short, known sequences, so that a bad shift or clear is seen one clock after the latch. A bad output stage is visible at once on `par_q` whenever the outputs are enabled. A missed or doubled edge detection shifts the whole latched word, so it shows up as a wrong value on the next latch.

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             shift_stb,
  input  logic             latch_stb,
  input  logic             clr_n,
  input  logic             oe_n,
  output logic [WIDTH-1:0] par_q,
  output logic             par_en,
  output logic             cas_out
);

  logic [WIDTH-1:0] sh_q;
  logic [WIDTH-1:0] out_q;
  logic             shift_d;
  logic             latch_d;
  logic             shift_edge;
  logic             latch_edge;

  assign shift_edge = shift_stb & ~shift_d;
  assign latch_edge = latch_stb & ~latch_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_d <= 1'b0;
      latch_d <= 1'b0;
    end else begin
      shift_d <= shift_stb;
      latch_d <= latch_stb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sh_q <= '0;
    else if (!clr_n)
      sh_q <= '0;
    else if (shift_edge)
      sh_q <= {sh_q[WIDTH-2:0], ser_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      out_q <= '0;
    else if (latch_edge)
      out_q <= sh_q;
  end

  assign par_en  = ~oe_n;
  assign par_q   = par_en ? out_q : '0;
  assign cas_out = sh_q[WIDTH-1];

  // R1
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb && !shift_d && clr_n) |=> sh_q == {$past(sh_q[WIDTH-2:0]), $past(ser_in)});

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_stb || latch_d) |=> $stable(out_q));

  // R3
  latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_stb && !latch_d) |=> out_q == $past(sh_q));

  // R4
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> sh_q == '0);

  // R10
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (sh_q == '0 && out_q == '0));

  // R5
  always_comb begin
    if (rst_n === 1'b1 && oe_n === 1'b1)
      oe_off_chk: assert (par_q == '0 && !par_en);
  end

endmodule

// File: tb/sipo_latch_reg_tb.sv
`timescale 1ns/1ps
module sipo_latch_reg_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0, shift_stb = 1'b0, latch_stb = 1'b0, clr_n = 1'b1, oe_n = 1'b0;
  logic [W-1:0] par_q, far_q;
  logic par_en, far_en, cas_out, far_cas;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sipo_latch_reg #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_stb(shift_stb),
    .latch_stb(latch_stb), .clr_n(clr_n), .oe_n(oe_n),
    .par_q(par_q), .par_en(par_en), .cas_out(cas_out));

  sipo_latch_reg #(.WIDTH(W)) far_i (
    .clk(clk), .rst_n(rst_n), .ser_in(cas_out), .shift_stb(shift_stb),
    .latch_stb(latch_stb), .clr_n(clr_n), .oe_n(oe_n),
    .par_q(far_q), .par_en(far_en), .cas_out(far_cas));

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); ser_in = b; shift_stb = 1'b1;
    @(negedge clk); shift_stb = 1'b0;
  endtask

  task automatic latch();
    @(negedge clk); latch_stb = 1'b1;
    @(negedge clk); latch_stb = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk); clr_n = 1'b0;
    @(negedge clk); clr_n = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) shift_bit(v[i]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(par_q == 8'h00 && cas_out == 1'b0, "R10", {8'h0, par_q}, 16'h0);
    check(par_en == 1'b1, "R10 enable", {15'h0, par_en}, 16'h1);
  endtask

  task automatic t_word();
    send_byte(8'hB1);
    check(par_q == 8'h00, "R2 hold during shift", {8'h0, par_q}, 16'h0);
    check(cas_out == 1'b1, "R6 cascade", {15'h0, cas_out}, 16'h1);
    latch();
    check(par_q == 8'hB1, "R3/R7 latched word", {8'h0, par_q}, 16'h00B1);
    check(par_q[7] == 1'b1, "R7 first bit on top", {15'h0, par_q[7]}, 16'h1);
  endtask

  task automatic t_shift_steps();
    clear();
    shift_bit(1'b1);
    latch();
    check(par_q == 8'h01, "R1 enters bit 0", {8'h0, par_q}, 16'h0001);
    shift_bit(1'b0);
    latch();
    check(par_q == 8'h02, "R1 moves up", {8'h0, par_q}, 16'h0002);
  endtask

  task automatic t_held_strobe();
    clear();
    @(negedge clk); ser_in = 1'b1; shift_stb = 1'b1;
    repeat (5) @(negedge clk);
    shift_stb = 1'b0;
    latch();
    check(par_q == 8'h01, "R11 one shift per edge", {8'h0, par_q}, 16'h0001);
  endtask

  task automatic t_clear();
    clear(); shift_bit(1'b1); shift_bit(1'b1); latch();
    send_byte(8'hFF);
    clear();
    check(par_q == 8'h03, "R4 output kept", {8'h0, par_q}, 16'h0003);
    check(cas_out == 1'b0, "R4 cascade cleared", {15'h0, cas_out}, 16'h0);
    @(negedge clk); clr_n = 1'b0; shift_stb = 1'b1; ser_in = 1'b1;
    @(negedge clk); clr_n = 1'b1; shift_stb = 1'b0;
    latch();
    check(par_q == 8'h00, "R4 clear over shift", {8'h0, par_q}, 16'h0);
  endtask

  task automatic t_oe();
    clear(); shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1); latch();
    @(negedge clk); oe_n = 1'b1;
    @(negedge clk);
    check(par_q == 8'h00 && par_en == 1'b0, "R5 disabled", {7'h0, par_en, par_q}, 16'h0);
    check(cas_out == 1'b0, "R6 cascade while disabled", {15'h0, cas_out}, 16'h0);
    oe_n = 1'b0;
    @(negedge clk);
    check(par_q == 8'h05 && par_en == 1'b1, "R5 re-enabled", {7'h0, par_en, par_q}, 16'h0105);
  endtask

  task automatic t_same_cycle();
    clear(); shift_bit(1'b1); latch();
    @(negedge clk); ser_in = 1'b1; shift_stb = 1'b1; latch_stb = 1'b1;
    @(negedge clk); shift_stb = 1'b0; latch_stb = 1'b0;
    check(par_q == 8'h01, "R9 pre-shift capture", {8'h0, par_q}, 16'h0001);
    latch();
    check(par_q == 8'h03, "R9 shift still applied", {8'h0, par_q}, 16'h0003);
  endtask

  task automatic t_chain();
    clear();
    send_byte(8'hA5);
    send_byte(8'hC3);
    latch();
    check(far_q == 8'hA5, "R8 far instance", {8'h0, far_q}, 16'h00A5);
    check(par_q == 8'hC3, "R8 near instance", {8'h0, par_q}, 16'h00C3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_word();
    t_shift_steps();
    t_held_strobe();
    t_clear();
    t_oe();
    t_same_cycle();
    t_chain();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule